// File: doc/BRIEF.md
# Condition Flag Update Unit

This block holds the five arithmetic condition flags of a processor datapath (extend, negative, zero, overflow, carry) and updates them after each data operation. The execution unit presents one operation per cycle: the operation class, the operand size (byte, word or long word), the source and destination operands, and the result it produced. On the next clock edge the block registers the new flag set.

Each operation class touches its own subset of flags. Moves and register-half swaps set the negative and zero flags and clear overflow and carry. Compares set four flags and leave extend alone. Add and subtract also copy carry into extend. Operations that target an address register leave every flag unchanged. A direct load writes the flags from the low byte of the source operand. The sign and zero tests look only at the bits that belong to the operand size, so stale upper bits in a byte or word result do not leak into the flags.

Top module: `ccr_update`

## Requirements
- R1: With op_class 0 (move), N takes the result's sign bit at the operand size, Z is set when the sized result is zero, V and C are cleared, and X is kept.
- R2: op_size 0 selects byte (bit 7, bits 7:0), 1 selects word (bit 15, bits 15:0), 2 and 3 select long (bit 31, bits 31:0). Operand and result bits above the size have no effect on any flag.
- R3: With op_class 1 (compare, result = destination minus source), N, Z, V and C are set as for a subtract, and X is kept.
- R4: With op_class 2 (subtract, result = destination minus source), C is set when the sized source is greater than the sized destination as unsigned values. V is set when source and destination signs differ and the result's sign differs from the destination's. X takes the new C.
- R5: With op_class 3 (add), C is the carry out of the top bit at the operand size. V is set when both operands have the same sign and the result's sign differs from it. X takes the new C.
- R6: With op_class 4 (address-register destination), all five flags are unchanged, whatever the size or operands.
- R7: With op_class 5 (swap of register halves), N is res_val bit 31 and Z is set when all 32 bits are zero, whatever op_size is. V and C are cleared and X is kept.
- R8: With op_class 6 (direct load), the flags take src_val bits 4:0 as X (bit 4), N (bit 3), Z (bit 2), V (bit 1), C (bit 0). Bits 31:5 are ignored.
- R9: With op_valid low, or with op_class 7, the flags are unchanged.
- R10: While rst_n is low, all flags are zero.
- R11: The flags for an operation presented in one cycle appear on ccr after the next rising clock edge. The ccr output packs X, N, Z, V, C in bits 4 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_class | input | 3 | Operation class code |
| op_size | input | 2 | Operand size code |
| src_val | input | 32 | Source operand |
| dst_val | input | 32 | Destination operand |
| res_val | input | 32 | Result produced by the execution unit |
| ccr | output | 5 | Registered flags {X, N, Z, V, C} |

## Verification
The hardest state to reach from the ports is a compare whose carry differs from the extend flag already held. This is the only case that shows compare leaving X alone rather than copying C into it. The stimulus reaches it by running an add that carries out, which sets X. A compare with no borrow follows, then a compare that borrows after a load has cleared X. The random phase masks operands to the chosen size and fills the bits above it with noise. Any leak of upper bits into the sign or zero test therefore shows up as a flag mismatch.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
    localparam int DATA_W = 32;
    localparam int FLAG_W = 5;

    typedef enum logic [2:0] {
        OPC_MOVE = 3'd0,
        OPC_CMP  = 3'd1,
        OPC_SUB  = 3'd2,
        OPC_ADD  = 3'd3,
        OPC_ADDR = 3'd4,
        OPC_SWAP = 3'd5,
        OPC_LOAD = 3'd6,
        OPC_NONE = 3'd7
    } op_class_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef struct packed {
        flags_t flags;
    } ccr_state_t;
endpackage

// File: rtl/ccr_size_view.sv
module ccr_size_view
    import ccr_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] val,
    input  logic [1:0]   size,
    output logic         msb,
    output logic         zero
);
    always_comb begin
        unique case (size)
            2'd0: begin
                msb  = val[7];
                zero = (val[7:0] == 8'd0);
            end
            2'd1: begin
                msb  = val[15];
                zero = (val[15:0] == 16'd0);
            end
            default: begin
                msb  = val[W-1];
                zero = (val == '0);
            end
        endcase
    end
endmodule

// File: rtl/ccr_carry_logic.sv
module ccr_carry_logic (
    input  logic s_msb,
    input  logic d_msb,
    input  logic r_msb,
    input  logic is_sub,
    output logic carry,
    output logic ovf
);
    always_comb begin
        if (is_sub) begin
            carry = (s_msb & ~d_msb) | (r_msb & ~d_msb) | (s_msb & r_msb);
            ovf   = (~s_msb & d_msb & ~r_msb) | (s_msb & ~d_msb & r_msb);
        end else begin
            carry = (s_msb & d_msb) | (~r_msb & d_msb) | (s_msb & ~r_msb);
            ovf   = (s_msb & d_msb & ~r_msb) | (~s_msb & ~d_msb & r_msb);
        end
    end
endmodule

// File: rtl/ccr_update.sv
module ccr_update
    import ccr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [2:0]        op_class,
    input  logic [1:0]        op_size,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] res_val,
    output logic [FLAG_W-1:0] ccr
);
    localparam int NVIEW = 3;

    ccr_state_t state_d, state_q;
    logic [DATA_W-1:0] view_val [NVIEW];
    logic [NVIEW-1:0]  view_msb;
    logic [NVIEW-1:0]  view_zero;
    logic              arith_c, arith_v, is_sub;
    op_class_e         opc;

    assign opc         = op_class_e'(op_class);
    assign view_val[0] = src_val;
    assign view_val[1] = dst_val;
    assign view_val[2] = res_val;

    for (genvar g = 0; g < NVIEW; g++) begin : g_view
        ccr_size_view #(.W(DATA_W)) u_view (
            .val  (view_val[g]),
            .size (op_size),
            .msb  (view_msb[g]),
            .zero (view_zero[g])
        );
    end

    assign is_sub = (opc != OPC_ADD);

    ccr_carry_logic u_carry (
        .s_msb  (view_msb[0]),
        .d_msb  (view_msb[1]),
        .r_msb  (view_msb[2]),
        .is_sub (is_sub),
        .carry  (arith_c),
        .ovf    (arith_v)
    );

    always_comb begin
        state_d = state_q;
        if (op_valid) begin
            unique case (opc)
                OPC_MOVE: begin
                    state_d.flags.n = view_msb[2];
                    state_d.flags.z = view_zero[2];
                    state_d.flags.v = 1'b0;
                    state_d.flags.c = 1'b0;
                end
                OPC_CMP: begin
                    state_d.flags.n = view_msb[2];
                    state_d.flags.z = view_zero[2];
                    state_d.flags.v = arith_v;
                    state_d.flags.c = arith_c;
                end
                OPC_SUB, OPC_ADD: begin
                    state_d.flags.x = arith_c;
                    state_d.flags.n = view_msb[2];
                    state_d.flags.z = view_zero[2];
                    state_d.flags.v = arith_v;
                    state_d.flags.c = arith_c;
                end
                OPC_SWAP: begin
                    state_d.flags.n = res_val[DATA_W-1];
                    state_d.flags.z = (res_val == '0);
                    state_d.flags.v = 1'b0;
                    state_d.flags.c = 1'b0;
                end
                OPC_LOAD: begin
                    state_d.flags = flags_t'(src_val[FLAG_W-1:0]);
                end
                default: begin
                    state_d = state_q;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ccr = state_q.flags;

    a_r1_move_clears_vc: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == 3'd0) |=> (ccr[1:0] == 2'b00 && ccr[4] == $past(ccr[4])));

    a_r3_cmp_keeps_x: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == 3'd1) |=> (ccr[4] == $past(ccr[4])));

    a_r4_sub_x_follows_c: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_class == 3'd2 || op_class == 3'd3)) |=> (ccr[4] == ccr[0]));

    a_r6_addr_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == 3'd4) |=> $stable(ccr));

    a_r7_swap_clears_vc: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == 3'd5) |=> (ccr[1:0] == 2'b00 && ccr[4] == $past(ccr[4])));

    a_r8_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class == 3'd6) |=> (ccr == $past(src_val[4:0])));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || op_class == 3'd7) |=> $stable(ccr));

    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (ccr == 5'd0));
endmodule

// File: tb/ccr_update_test.sv
module ccr_update_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [2:0]  op_class = 3'd0;
    logic [1:0]  op_size = 2'd0;
    logic [31:0] src_val = '0, dst_val = '0, res_val = '0;
    logic [4:0]  ccr;
    logic [4:0]  model = 5'd0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ccr_update uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .op_size(op_size), .src_val(src_val), .dst_val(dst_val),
        .res_val(res_val), .ccr(ccr)
    );

    function automatic int width_of(input logic [1:0] sz);
        return (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    endfunction

    function automatic logic [32:0] mask_of(input logic [1:0] sz);
        return (33'd1 << width_of(sz)) - 33'd1;
    endfunction

    function automatic logic [4:0] expect_flags(input logic [4:0] old,
            input logic valid, input logic [2:0] op, input logic [1:0] sz,
            input logic [31:0] s, input logic [31:0] d, input logic [31:0] r);
        logic [32:0] m, sm, dm, rm, sum;
        int w;
        logic sn, dn, rn, x, n, z, v, c;
        w  = width_of(sz);
        m  = mask_of(sz);
        sm = {1'b0, s} & m;
        dm = {1'b0, d} & m;
        rm = {1'b0, r} & m;
        sn = sm[w-1]; dn = dm[w-1]; rn = rm[w-1];
        {x, n, z, v, c} = old;
        if (!valid) return old;
        case (op)
            3'd0: begin n = rn; z = (rm == 0); v = 0; c = 0; end
            3'd1, 3'd2: begin
                n = rn; z = (rm == 0);
                c = (sm > dm);
                v = (sn != dn) && (rn != dn);
                if (op == 3'd2) x = c;
            end
            3'd3: begin
                sum = sm + dm;
                n = rn; z = (rm == 0);
                c = sum[w];
                v = (sn == dn) && (rn != sn);
                x = c;
            end
            3'd5: begin n = r[31]; z = (r == 0); v = 0; c = 0; end
            3'd6: {x, n, z, v, c} = s[4:0];
            default: ;
        endcase
        return {x, n, z, v, c};
    endfunction

    function automatic string tag_of(input logic valid, input logic [2:0] op);
        if (!valid) return "R9";
        case (op)
            3'd0: return "R1";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3: return "R5";
            3'd4: return "R6";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [4:0] exp);
        checks++;
        if (ccr !== exp) begin
            errors++;
            $display("FAIL %s: ccr=%05b expected=%05b", tag, ccr, exp);
        end
    endtask

    // Drive on the falling edge; the result registers at the next rising
    // edge (R11) and is sampled at the following falling edge.
    task automatic apply(input logic valid, input logic [2:0] op,
            input logic [1:0] sz, input logic [31:0] s, input logic [31:0] d,
            input logic [31:0] r, input string tag);
        op_valid = valid; op_class = op; op_size = sz;
        src_val = s; dst_val = d; res_val = r;
        model = expect_flags(model, valid, op, sz, s, d, r);
        @(negedge clk);
        check(tag, model);
    endtask

    task automatic run_op(input logic [2:0] op, input logic [1:0] sz,
            input logic [31:0] s, input logic [31:0] d, input logic [31:0] junk);
        logic [31:0] r, m;
        m = mask_of(sz);
        case (op)
            3'd0: r = s;
            3'd1, 3'd2: r = d - s;
            3'd3: r = d + s;
            3'd5: r = {s[15:0], s[31:16]};
            default: r = junk;
        endcase
        if (op != 3'd5 && op != 3'd4) r = (r & m) | (junk & ~m);
        apply(1'b1, op, sz, s, d, r, tag_of(1'b1, op));
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        @(negedge clk);
        check("R10", 5'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 load, upper bits ignored
        apply(1, 3'd6, 2'd0, 32'hFFFF_FFE0 | 32'h15, 0, 0, "R8");
        // R9 idle and op 7 hold
        apply(0, 3'd0, 2'd0, 0, 0, 0, "R9");
        apply(1, 3'd7, 2'd0, 0, 0, 0, "R9");
        // R6 address op with garbage leaves flags
        apply(1, 3'd4, 2'd1, 32'h0000_8000, 32'h1, 32'h0, "R6");
        // R1 / R2 byte move with upper garbage, zero at size
        apply(1, 3'd0, 2'd0, 32'h1234_5600, 0, 32'hABCD_EF00, "R2");
        apply(1, 3'd0, 2'd1, 32'h0000_8001, 0, 32'hFFFF_8001, "R1");
        apply(1, 3'd0, 2'd3, 32'h8000_0000, 0, 32'h8000_0000, "R2");
        // R5 byte add carry out, sets X
        run_op(3'd3, 2'd0, 32'h01, 32'hFF, 32'h5A5A_5A00);
        // R3 compare no borrow keeps X=1 while C=0
        run_op(3'd1, 2'd0, 32'h01, 32'h02, 32'h0);
        // clear then compare with borrow: X stays 0 while C=1
        apply(1, 3'd6, 2'd0, 32'h0, 0, 0, "R8");
        run_op(3'd1, 2'd1, 32'h0002, 32'h0001, 32'hFFFF_0000);
        // R4 byte overflow 0x80 - 0x01
        run_op(3'd2, 2'd0, 32'h01, 32'h80, 32'h0);
        // R4 word borrow
        run_op(3'd2, 2'd1, 32'h0001, 32'h0000, 32'h0);
        // R5 long overflow
        run_op(3'd3, 2'd2, 32'h7FFF_FFFF, 32'h0000_0001, 32'h0);
        // R7 swap ignores size
        apply(1, 3'd5, 2'd0, 0, 0, 32'h0001_0000, "R7");
        apply(1, 3'd5, 2'd0, 0, 0, 32'h0000_0000, "R7");

        for (int i = 0; i < 3000; i++) begin
            logic [2:0] op;
            logic [1:0] sz;
            logic [31:0] s, d, j;
            op = 3'($urandom_range(0, 7));
            sz = 2'($urandom_range(0, 3));
            s = $urandom; d = $urandom; j = $urandom;
            if ($urandom_range(0, 3) == 0) s = s & 32'h8000_0001;
            if ($urandom_range(0, 3) == 0) d = s;
            if ($urandom_range(0, 9) == 0)
                apply(1'b0, op, sz, s, d, j, "R9");
            else
                run_op(op, sz, s, d, j);
        end

        rst_n = 1'b0;
        #1;
        check("R10", 5'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule